// File: doc/BRIEF.md
# Lane Alignment Sequence Checker

This block sits on one receive lane of a high-speed serial converter link, after the stage that has already locked onto character boundaries. Each cycle it may accept one decoded octet together with a flag that marks control characters. A start pulse from the character synchronizer arms it. It then hunts for the first frame-start character and follows the four-multiframe alignment sequence. It checks that every alignment character sits where the structure puts it. It captures the configuration octets carried in the second multiframe and compares them with the link parameters programmed on its input pins.

When the fourth multiframe closes correctly, the lane enters data mode. User octets come out one cycle later, with markers for frame end and multiframe end. The checker keeps watching the two alignment characters that a transmitter may substitute for the last octet of a frame or a multiframe. A misplaced one is flagged, and a programmable number of them raises a resynchronization request. Frame length F and frames per multiframe K are programmed as F-1 and K-1, and a multiframe is K×F octets long. The product must be at least 10, so that the second multiframe can hold its configuration.

Top module: `lane_align_rx`

## Requirements
- R1: After reset, and with no start pulse yet, `linkUp`, `outValid`, `seqErr`, `cfgErr`, `alignErr` and `resyncReq` are all low.
- R2: After a start pulse, every octet before the first control octet 0x1C is ignored: no flag is set and `linkUp` stays low. That 0x1C is taken as position 0 of the first multiframe.
- R3: Within the four multiframes, position 0 must be control 0x1C and position K×F-1 must be control 0x7C. In the second multiframe, position 1 must be control 0x9C. Every other position must be a non-control octet. A violation sets the sticky `seqErr` and sends the checker back to hunting for 0x1C.
- R4: Positions 2 to 8 of the second multiframe must be non-control octets equal to L-1, M-1, F-1, S-1, N-1, N′-1 and CS, in that order, each zero-extended to 8 bits. Any difference sets the sticky `cfgErr`, and the sequence continues.
- R5: `linkUp` rises on the cycle after the 0x7C that closes the fourth multiframe. The first octet after it is the first one presented with `outValid` high, one cycle after it is accepted.
- R6: In data mode each accepted octet appears on `outOctet`/`outCtrl` one cycle later. `outFrameEnd` is high when it was the last octet of a frame, and `outMfEnd` is high when it was the last octet of a multiframe.
- R7: In data mode, control 0xFC at any position other than a frame end, or control 0x7C at any position other than a multiframe end, sets the sticky `alignErr`. At the expected positions neither character sets it.
- R8: After ERR_LIMIT misplaced characters since the last start, `resyncReq` goes high and stays high until the next start.
- R9: A cycle with `inValid` low advances no position counter and produces `outValid` low.
- R10: A start pulse at any time clears every flag, drops `linkUp`, and returns the checker to hunting. It takes priority over an octet accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse from the character synchronizer: restart the hunt |
| inValid | input | 1 | An octet is present this cycle |
| inOctet | input | 8 | Decoded octet |
| inCtrl | input | 1 | Octet is a control character |
| cfgLanesM1 | input | 5 | Programmed lanes minus one |
| cfgConvM1 | input | 8 | Programmed converters minus one |
| cfgOctM1 | input | 8 | Programmed octets per frame minus one |
| cfgSampM1 | input | 5 | Programmed samples per frame minus one |
| cfgResM1 | input | 5 | Programmed resolution minus one |
| cfgTotM1 | input | 5 | Programmed total bits per sample minus one |
| cfgCtrlBits | input | 2 | Programmed control bits per sample |
| cfgFrmM1 | input | 5 | Programmed frames per multiframe minus one |
| linkUp | output | 1 | Data mode active |
| outValid | output | 1 | User octet valid |
| outOctet | output | 8 | User octet |
| outCtrl | output | 1 | User octet was a control character |
| outFrameEnd | output | 1 | Octet was the last of its frame |
| outMfEnd | output | 1 | Octet was the last of its multiframe |
| seqErr | output | 1 | Sticky structural error in the alignment sequence |
| cfgErr | output | 1 | Sticky configuration mismatch |
| alignErr | output | 1 | Sticky misplaced alignment character in data mode |
| resyncReq | output | 1 | Misplacement count reached ERR_LIMIT |

## Verification
The bench programs two octets per frame and eight frames per multiframe. Each multiframe is then 16 octets, and the frame ends fall on every odd position. Legal and illegal spots for both alignment characters therefore appear within a single multiframe, and the full sequence takes 64 octets. It builds the block with ERR_LIMIT set to 3, so the resynchronization threshold is reached after a few misplacements. This also shows that the request stays low on the count just below the limit.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

  localparam logic [7:0] CH_START = 8'h1C;  // multiframe start
  localparam logic [7:0] CH_ALIGN = 8'h7C;  // multiframe end / lane align
  localparam logic [7:0] CH_CONF  = 8'h9C;  // configuration follows
  localparam logic [7:0] CH_FRAME = 8'hFC;  // frame end substitute

  localparam int CFG_FIRST  = 2;  // first config position in the second multiframe
  localparam int CFG_OCTETS = 7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HUNT,
    ST_SEQ,
    ST_DATA
  } laState_t;

  typedef struct packed {
    logic cntClear;  // current octet is position 0
    logic cntStep;   // advance position counters
    logic outEn;     // present current octet as user data
  } laStrobe_t;

endpackage

// File: rtl/lane_align_dp.sv
module lane_align_dp
  import lane_align_pkg::*;
#(
  parameter int F_W = 8,
  parameter int K_W = 5,
  localparam int POS_W = F_W + K_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  laStrobe_t        strb,
  input  logic [7:0]       inOctet,
  input  logic             inCtrl,
  input  logic [F_W-1:0]   octPerFrameM1,
  input  logic [K_W-1:0]   frmPerMfM1,
  input  logic [4:0]       cfgLanesM1,
  input  logic [7:0]       cfgConvM1,
  input  logic [4:0]       cfgSampM1,
  input  logic [4:0]       cfgResM1,
  input  logic [4:0]       cfgTotM1,
  input  logic [1:0]       cfgCtrlBits,
  output logic [POS_W-1:0] mfPos,
  output logic [1:0]       mfIdx,
  output logic             atFrameEnd,
  output logic             atMfEnd,
  output logic             inCfgSlot,
  output logic             cfgBad,
  output logic             outValid,
  output logic [7:0]       outOctet,
  output logic             outCtrl,
  output logic             outFrameEnd,
  output logic             outMfEnd
);

  logic [F_W-1:0]   framePos;
  logic [K_W-1:0]   frameCnt;
  logic [POS_W-1:0] mfPosQ;
  logic [1:0]       mfIdxQ;

  // source of the step: zeros when the current octet is the first start char
  logic [F_W-1:0]   srcFp;
  logic [K_W-1:0]   srcFc;
  logic [POS_W-1:0] srcMp;
  logic [1:0]       srcMi;
  logic             srcFrameEnd;
  logic             srcMfEnd;

  always_comb begin
    srcFp       = strb.cntClear ? '0 : framePos;
    srcFc       = strb.cntClear ? '0 : frameCnt;
    srcMp       = strb.cntClear ? '0 : mfPosQ;
    srcMi       = strb.cntClear ? '0 : mfIdxQ;
    srcFrameEnd = (srcFp == octPerFrameM1);
    srcMfEnd    = srcFrameEnd && (srcFc == frmPerMfM1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      framePos <= '0;
      frameCnt <= '0;
      mfPosQ   <= '0;
      mfIdxQ   <= '0;
    end else if (strb.cntStep) begin
      framePos <= srcFrameEnd ? '0 : srcFp + 1'b1;
      frameCnt <= srcMfEnd ? '0 : (srcFrameEnd ? srcFc + 1'b1 : srcFc);
      mfPosQ   <= srcMfEnd ? '0 : srcMp + 1'b1;
      mfIdxQ   <= srcMfEnd ? srcMi + 2'd1 : srcMi;
    end
  end

  assign mfPos      = mfPosQ;
  assign mfIdx      = mfIdxQ;
  assign atFrameEnd = (framePos == octPerFrameM1);
  assign atMfEnd    = atFrameEnd && (frameCnt == frmPerMfM1);

  // configuration slot decode and compare
  logic [POS_W-1:0] cfgOff;
  logic [2:0]       cfgSel;
  logic [7:0]       cfgExp;

  always_comb begin
    cfgOff    = mfPosQ - POS_W'(CFG_FIRST);
    cfgSel    = cfgOff[2:0];
    inCfgSlot = (mfIdxQ == 2'd1) && (mfPosQ >= POS_W'(CFG_FIRST))
                && (mfPosQ < POS_W'(CFG_FIRST + CFG_OCTETS));
    case (cfgSel)
      3'd0:    cfgExp = 8'(cfgLanesM1);
      3'd1:    cfgExp = cfgConvM1;
      3'd2:    cfgExp = 8'(octPerFrameM1);
      3'd3:    cfgExp = 8'(cfgSampM1);
      3'd4:    cfgExp = 8'(cfgResM1);
      3'd5:    cfgExp = 8'(cfgTotM1);
      3'd6:    cfgExp = 8'(cfgCtrlBits);
      default: cfgExp = 8'h00;
    endcase
    cfgBad = inCfgSlot && (inCtrl || (inOctet != cfgExp));
  end

  // user data register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outOctet    <= '0;
      outCtrl     <= 1'b0;
      outFrameEnd <= 1'b0;
      outMfEnd    <= 1'b0;
    end else begin
      outValid <= strb.outEn;
      if (strb.outEn) begin
        outOctet    <= inOctet;
        outCtrl     <= inCtrl;
        outFrameEnd <= atFrameEnd;
        outMfEnd    <= atMfEnd;
      end
    end
  end

  // R3
  pos_consistent_chk: assert property (@(posedge clk) disable iff (!rstN)
    mfPosQ == (POS_W'(frameCnt) * (POS_W'(octPerFrameM1) + 1'b1) + POS_W'(framePos)));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cntStep |=> $stable(mfPosQ) && $stable(mfIdxQ));

  // R6
  mf_end_frame_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    outMfEnd |-> outFrameEnd);

endmodule

// File: rtl/lane_align_ctrl.sv
module lane_align_ctrl
  import lane_align_pkg::*;
#(
  parameter int POS_W     = 13,
  parameter int ERR_LIMIT = 4,
  localparam int ERR_W    = $clog2(ERR_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             inValid,
  input  logic [7:0]       inOctet,
  input  logic             inCtrl,
  input  logic [POS_W-1:0] mfPos,
  input  logic [1:0]       mfIdx,
  input  logic             atFrameEnd,
  input  logic             atMfEnd,
  input  logic             inCfgSlot,
  input  logic             cfgBad,
  output laStrobe_t        strb,
  output logic             linkUp,
  output logic             seqErr,
  output logic             cfgErr,
  output logic             alignErr,
  output logic             resyncReq
);

  laState_t   st, stNext;
  logic [ERR_W-1:0] errCnt;

  logic isStart, isAlign, isConf, isFrame;
  logic seqBad, cfgHit, alignBad;

  always_comb begin
    isStart = inCtrl && (inOctet == CH_START);
    isAlign = inCtrl && (inOctet == CH_ALIGN);
    isConf  = inCtrl && (inOctet == CH_CONF);
    isFrame = inCtrl && (inOctet == CH_FRAME);
  end

  always_comb begin
    stNext   = st;
    strb     = '0;
    seqBad   = 1'b0;
    cfgHit   = 1'b0;
    alignBad = 1'b0;
    if (start) begin
      stNext = ST_HUNT;
    end else if (inValid) begin
      case (st)
        ST_HUNT: begin
          if (isStart) begin
            strb.cntClear = 1'b1;
            strb.cntStep  = 1'b1;
            stNext        = ST_SEQ;
          end
        end
        ST_SEQ: begin
          strb.cntStep = 1'b1;
          if (mfPos == '0)                          seqBad = !isStart;
          else if (atMfEnd)                         seqBad = !isAlign;
          else if (mfIdx == 2'd1 && mfPos == POS_W'(1)) seqBad = !isConf;
          else if (inCfgSlot)                       cfgHit = cfgBad;
          else                                      seqBad = inCtrl;
          if (seqBad)                               stNext = ST_HUNT;
          else if (atMfEnd && mfIdx == 2'd3)        stNext = ST_DATA;
        end
        ST_DATA: begin
          strb.cntStep = 1'b1;
          strb.outEn   = 1'b1;
          alignBad     = (isAlign && !atMfEnd) || (isFrame && !atFrameEnd);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st        <= ST_IDLE;
      seqErr    <= 1'b0;
      cfgErr    <= 1'b0;
      alignErr  <= 1'b0;
      resyncReq <= 1'b0;
      errCnt    <= '0;
    end else if (start) begin
      st        <= stNext;
      seqErr    <= 1'b0;
      cfgErr    <= 1'b0;
      alignErr  <= 1'b0;
      resyncReq <= 1'b0;
      errCnt    <= '0;
    end else begin
      st <= stNext;
      if (seqBad)   seqErr   <= 1'b1;
      if (cfgHit)   cfgErr   <= 1'b1;
      if (alignBad) alignErr <= 1'b1;
      if (alignBad && errCnt != ERR_W'(ERR_LIMIT)) errCnt <= errCnt + 1'b1;
      if (alignBad && errCnt == ERR_W'(ERR_LIMIT - 1)) resyncReq <= 1'b1;
    end
  end

  assign linkUp = (st == ST_DATA);

  // R5
  data_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkUp) |-> $past(inValid && isAlign && !start));

  // R8
  resync_needs_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    resyncReq |-> alignErr);

  // R10
  start_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !linkUp && !seqErr && !cfgErr && !alignErr && !resyncReq);

  // R3
  seq_err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqErr && !start |=> seqErr);

  // R9
  stall_link_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid && !start |=> $stable(linkUp));

endmodule

// File: rtl/lane_align_rx.sv
module lane_align_rx
  import lane_align_pkg::*;
#(
  parameter int F_W       = 8,
  parameter int K_W       = 5,
  parameter int ERR_LIMIT = 4,
  localparam int POS_W    = F_W + K_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic           inValid,
  input  logic [7:0]     inOctet,
  input  logic           inCtrl,
  input  logic [4:0]     cfgLanesM1,
  input  logic [7:0]     cfgConvM1,
  input  logic [F_W-1:0] cfgOctM1,
  input  logic [4:0]     cfgSampM1,
  input  logic [4:0]     cfgResM1,
  input  logic [4:0]     cfgTotM1,
  input  logic [1:0]     cfgCtrlBits,
  input  logic [K_W-1:0] cfgFrmM1,
  output logic           linkUp,
  output logic           outValid,
  output logic [7:0]     outOctet,
  output logic           outCtrl,
  output logic           outFrameEnd,
  output logic           outMfEnd,
  output logic           seqErr,
  output logic           cfgErr,
  output logic           alignErr,
  output logic           resyncReq
);

  laStrobe_t        strb;
  logic [POS_W-1:0] mfPos;
  logic [1:0]       mfIdx;
  logic             atFrameEnd, atMfEnd, inCfgSlot, cfgBad;

  lane_align_ctrl #(
    .POS_W     (POS_W),
    .ERR_LIMIT (ERR_LIMIT)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .inValid    (inValid),
    .inOctet    (inOctet),
    .inCtrl     (inCtrl),
    .mfPos      (mfPos),
    .mfIdx      (mfIdx),
    .atFrameEnd (atFrameEnd),
    .atMfEnd    (atMfEnd),
    .inCfgSlot  (inCfgSlot),
    .cfgBad     (cfgBad),
    .strb       (strb),
    .linkUp     (linkUp),
    .seqErr     (seqErr),
    .cfgErr     (cfgErr),
    .alignErr   (alignErr),
    .resyncReq  (resyncReq)
  );

  lane_align_dp #(
    .F_W (F_W),
    .K_W (K_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .inOctet       (inOctet),
    .inCtrl        (inCtrl),
    .octPerFrameM1 (cfgOctM1),
    .frmPerMfM1    (cfgFrmM1),
    .cfgLanesM1    (cfgLanesM1),
    .cfgConvM1     (cfgConvM1),
    .cfgSampM1     (cfgSampM1),
    .cfgResM1      (cfgResM1),
    .cfgTotM1      (cfgTotM1),
    .cfgCtrlBits   (cfgCtrlBits),
    .mfPos         (mfPos),
    .mfIdx         (mfIdx),
    .atFrameEnd    (atFrameEnd),
    .atMfEnd       (atMfEnd),
    .inCfgSlot     (inCfgSlot),
    .cfgBad        (cfgBad),
    .outValid      (outValid),
    .outOctet      (outOctet),
    .outCtrl       (outCtrl),
    .outFrameEnd   (outFrameEnd),
    .outMfEnd      (outMfEnd)
  );

endmodule

// File: tb/lane_align_rx_bench.sv
module lane_align_rx_bench;

  localparam int F_W = 8;
  localparam int K_W = 5;
  localparam int ERR_LIMIT = 3;
  localparam int OCT_PER_FRAME = 2;
  localparam int FRM_PER_MF = 8;
  localparam int MF_LEN = OCT_PER_FRAME * FRM_PER_MF;

  // programmed values (already minus one where applicable)
  localparam logic [7:0] V_L  = 8'd3;
  localparam logic [7:0] V_M  = 8'd1;
  localparam logic [7:0] V_F  = 8'd1;
  localparam logic [7:0] V_S  = 8'd0;
  localparam logic [7:0] V_N  = 8'd11;
  localparam logic [7:0] V_NP = 8'd15;
  localparam logic [7:0] V_CS = 8'd0;

  typedef struct packed {
    logic [7:0] ch;
    logic [3:0] pos;
    logic       expErr;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{ch: 8'hFC, pos: 4'd1,  expErr: 1'b0},
    '{ch: 8'hFC, pos: 4'd2,  expErr: 1'b1},
    '{ch: 8'h7C, pos: 4'd15, expErr: 1'b0},
    '{ch: 8'h7C, pos: 4'd7,  expErr: 1'b1},
    '{ch: 8'hFC, pos: 4'd15, expErr: 1'b0},
    '{ch: 8'hFC, pos: 4'd9,  expErr: 1'b0},
    '{ch: 8'h7C, pos: 4'd14, expErr: 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inOctet = '0;
  logic inCtrl = 1'b0;
  logic linkUp, outValid, outCtrl, outFrameEnd, outMfEnd;
  logic [7:0] outOctet;
  logic seqErr, cfgErr, alignErr, resyncReq;

  int nChk = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  lane_align_rx #(
    .F_W (F_W), .K_W (K_W), .ERR_LIMIT (ERR_LIMIT)
  ) u_lane_align_rx (
    .clk (clk), .rstN (rstN), .start (start),
    .inValid (inValid), .inOctet (inOctet), .inCtrl (inCtrl),
    .cfgLanesM1 (V_L[4:0]), .cfgConvM1 (V_M), .cfgOctM1 (V_F),
    .cfgSampM1 (V_S[4:0]), .cfgResM1 (V_N[4:0]), .cfgTotM1 (V_NP[4:0]),
    .cfgCtrlBits (V_CS[1:0]), .cfgFrmM1 (5'(FRM_PER_MF - 1)),
    .linkUp (linkUp), .outValid (outValid), .outOctet (outOctet),
    .outCtrl (outCtrl), .outFrameEnd (outFrameEnd), .outMfEnd (outMfEnd),
    .seqErr (seqErr), .cfgErr (cfgErr), .alignErr (alignErr),
    .resyncReq (resyncReq)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic sendOct(input logic [7:0] o, input logic c);
    inOctet = o;
    inCtrl  = c;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic idleCycle();
    inValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseStart();
    start = 1'b1;
    inValid = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic logic [7:0] cfgVal(input int i);
    case (i)
      0: return V_L;
      1: return V_M;
      2: return V_F;
      3: return V_S;
      4: return V_N;
      5: return V_NP;
      default: return V_CS;
    endcase
  endfunction

  // four multiframes; badCfg flips one config octet, brkMf/brkPos replace one octet with plain data
  task automatic sendSeq(input int badCfg, input int brkMf, input int brkPos, input bit chkLink);
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < MF_LEN; p++) begin
        logic [7:0] o;
        logic c;
        if (p == 0)                          begin o = 8'h1C; c = 1'b1; end
        else if (p == MF_LEN - 1)            begin o = 8'h7C; c = 1'b1; end
        else if (m == 1 && p == 1)           begin o = 8'h9C; c = 1'b1; end
        else if (m == 1 && p >= 2 && p <= 8) begin
          o = cfgVal(p - 2) ^ ((p - 2 == badCfg) ? 8'h01 : 8'h00);
          c = 1'b0;
        end
        else                                 begin o = 8'(p); c = 1'b0; end
        if (m == brkMf && p == brkPos)       begin o = 8'h33; c = 1'b0; end
        sendOct(o, c);
        if (chkLink && m == 3 && p == MF_LEN - 2)
          chk("R5 linkUp low before last align char", 32'(linkUp), 32'd0);
        if (chkLink && m == 3 && p == MF_LEN - 1)
          chk("R5 linkUp after fourth align char", 32'(linkUp), 32'd1);
      end
    end
  endtask

  // one data multiframe with an optional control char at position pos
  task automatic sendDataMf(input logic [7:0] ch, input int pos);
    for (int p = 0; p < MF_LEN; p++) begin
      if (p == pos) sendOct(ch, 1'b1);
      else          sendOct(8'(8'h40 + p), 1'b0);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 linkUp", 32'(linkUp), 32'd0);
    chk("R1 outValid", 32'(outValid), 32'd0);
    chk("R1 flags", {28'd0, seqErr, cfgErr, alignErr, resyncReq}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 flags after release", {27'd0, linkUp, seqErr, cfgErr, alignErr, resyncReq}, 32'd0);

    // R2 octets ahead of the first start char are ignored
    pulseStart();
    sendOct(8'h55, 1'b0);
    sendOct(8'h7C, 1'b1);
    sendOct(8'h9C, 1'b1);
    chk("R2 no flag before start char", {28'd0, seqErr, cfgErr, alignErr, resyncReq}, 32'd0);
    chk("R2 linkUp low while hunting", 32'(linkUp), 32'd0);

    // R3 R4 R5 clean sequence
    sendSeq(-1, -1, -1, 1'b1);
    chk("R3 seqErr clear on good sequence", 32'(seqErr), 32'd0);
    chk("R4 cfgErr clear on matching config", 32'(cfgErr), 32'd0);

    // R5 R6 first user octets
    sendOct(8'h5A, 1'b0);
    chk("R5 outValid first data octet", 32'(outValid), 32'd1);
    chk("R6 outOctet first", 32'(outOctet), 32'h5A);
    chk("R6 frame end at pos0", {30'd0, outFrameEnd, outMfEnd}, 32'd0);
    sendOct(8'hA5, 1'b0);
    chk("R6 frame end at pos1", {30'd0, outFrameEnd, outMfEnd}, 32'b10);
    // R9 stall
    idleCycle();
    chk("R9 outValid low on gap", 32'(outValid), 32'd0);
    sendOct(8'h01, 1'b0);
    chk("R9 position held across gap", 32'(outFrameEnd), 32'd0);
    sendOct(8'hFC, 1'b1);
    chk("R6 control passthrough", {23'd0, outCtrl, outOctet}, 32'h1FC);
    chk("R7 frame char at frame end accepted", 32'(alignErr), 32'd0);
    for (int p = 4; p < MF_LEN; p++) sendOct(8'(p), 1'b0);
    chk("R6 multiframe end marker", {30'd0, outFrameEnd, outMfEnd}, 32'b11);

    // R7 table of alignment char placements
    for (int i = 0; i < NVEC; i++) begin
      pulseStart();
      sendSeq(-1, -1, -1, 1'b0);
      sendDataMf(VECS[i].ch, int'(VECS[i].pos));
      chk($sformatf("R7 vec %0d alignErr", i), 32'(alignErr), 32'(VECS[i].expErr));
      chk($sformatf("R8 vec %0d no resync on single error", i), 32'(resyncReq), 32'd0);
    end

    // R8 resync after ERR_LIMIT misplacements
    pulseStart();
    sendSeq(-1, -1, -1, 1'b0);
    sendOct(8'h7C, 1'b1);  // pos0
    sendOct(8'h10, 1'b0);  // pos1
    sendOct(8'hFC, 1'b1);  // pos2
    chk("R8 below limit", 32'(resyncReq), 32'd0);
    sendOct(8'h11, 1'b0);  // pos3
    sendOct(8'hFC, 1'b1);  // pos4
    chk("R8 limit reached", 32'(resyncReq), 32'd1);
    sendOct(8'h12, 1'b0);
    chk("R8 request held", 32'(resyncReq), 32'd1);

    // R10 start clears everything
    pulseStart();
    chk("R10 cleared by start", {27'd0, linkUp, seqErr, cfgErr, alignErr, resyncReq}, 32'd0);

    // R4 configuration mismatch on the resolution octet
    sendSeq(4, -1, -1, 1'b0);
    chk("R4 cfgErr on mismatch", 32'(cfgErr), 32'd1);
    chk("R4 sequence continues", {30'd0, linkUp, seqErr}, 32'b10);

    // R3 missing align char at end of third multiframe
    pulseStart();
    sendSeq(-1, 2, MF_LEN - 1, 1'b0);
    chk("R3 seqErr on missing align char", 32'(seqErr), 32'd1);
    chk("R3 no data mode after error", 32'(linkUp), 32'd0);

    // R3 missing configuration marker
    pulseStart();
    sendSeq(-1, 1, 1, 1'b0);
    chk("R3 seqErr on missing config marker", 32'(seqErr), 32'd1);

    // R10 start during traffic wins and recovery works
    start = 1'b1;
    inOctet = 8'h1C;
    inCtrl = 1'b1;
    inValid = 1'b1;
    @(negedge clk);
    start = 1'b0;
    inValid = 1'b0;
    chk("R10 start wins over octet", {30'd0, linkUp, seqErr}, 32'd0);
    sendSeq(-1, -1, -1, 1'b0);
    chk("R10 recovery to data mode", {30'd0, linkUp, seqErr}, 32'b10);

    report();
  end

endmodule